// File: doc/BRIEF.md
# Dual-Parallel Serial Flash Striping Engine

This block is the master-side shift engine for a pair of serial flash devices wired side by side so that software sees them as one memory of twice the capacity. The two devices share a single serial clock and a single active-low select. Each device keeps its own data lines, called the lower bus and the upper bus. A transfer is started with a one-cycle `start` strobe that carries the target, the bus width, the direction, the start address and the byte count. Write data then arrives on a valid/ready byte input, and read data leaves on a valid/ready byte output.

The target selects one of four ways to use the pair. Mirror sends every byte to both devices, which suits commands and addresses. Lower-only and upper-only talk to one device and leave the other bus undriven. Striped mode deals consecutive logical bytes alternately to the lower and upper device and shifts each pair in the same clock pulses. Each bus can be one, two or four lines wide. The serial clock runs at half the system clock, with one system cycle low and one high per bit period. Clock division and multi-phase command sequencing are left to the surrounding logic.

Top module: `dpar_flash_stripe`

## Requirements
- R1: After reset and between transfers, `cs_n` is 1, `sck` is 0, both output-enable vectors are 0, and `done`, `err`, `tx_ready` and `rx_valid` are 0.
- R2: `cfg_wid` encodes the bus width: 00 is single (output on line 0, input on line 1), 01 is dual (lines 1:0, MSB on line 1) and 10 is quad (lines 3:0, MSB on line 3). Bits move MSB first, so a byte takes 8, 4 or 2 `sck` pulses. Outputs change only as `sck` falls, inputs are sampled as `sck` rises, and `sck` is low whenever `cs_n` is high.
- R3: `cfg_tgt` encodes the target: 00 mirror, 01 lower only, 10 upper only, 11 striped. A mirror write puts the same byte on both buses.
- R4: For the lower-only target the upper output enables stay 0 for the whole transfer; for the upper-only target the lower output enables stay 0.
- R5: A striped write sends logical bytes 0, 2, 4… on the lower bus and bytes 1, 3, 5… on the upper bus, each pair in the same `sck` pulses.
- R6: A striped read returns, for each pair, the lower-bus byte first and the upper-bus byte second.
- R7: During reads neither bus is driven. A mirror read returns the lower-bus byte and ignores the upper bus; an upper-only read returns the upper-bus byte.
- R8: The request is rejected when the length is zero, when `cfg_wid` is 11, or when the target is striped and either `cfg_addr[0]` or `cfg_len[0]` is 1. A rejected request gives a one-cycle `err` pulse, no `done`, no `cs_n` assertion and no `sck` edges.
- R9: `cs_n` is low in the cycle before every rising `sck`. After the last falling `sck` of a write, `cs_n` stays low for exactly one more cycle. `done` is a one-cycle pulse with `cs_n` high, and it ends every accepted transfer.
- R10: In striped writes no `sck` pulse of a pair occurs until both of its bytes have been accepted, and `tx_ready` is never high while `sck` is high.
- R11: While a read byte waits on `rx_ready`, `sck` stays low and `rx_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer with the cfg_* values (ignored unless idle) |
| cfg_tgt | input | 2 | Target: mirror, lower, upper, striped |
| cfg_wid | input | 2 | Lines per bus: single, dual, quad |
| cfg_rd | input | 1 | 1 = read, 0 = write |
| cfg_addr | input | ADDR_W | Logical start address (bit 0 checked) |
| cfg_len | input | LEN_W | Byte count |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | One-cycle rejected-request pulse |
| tx_data | input | 8 | Write byte |
| tx_valid | input | 1 | Write byte present |
| tx_ready | output | 1 | Write byte taken this cycle if valid |
| rx_data | output | 8 | Read byte |
| rx_valid | output | 1 | Read byte present |
| rx_ready | input | 1 | Consumer takes read byte |
| sck | output | 1 | Shared serial clock |
| cs_n | output | 1 | Shared active-low select |
| lo_o | output | 4 | Lower bus output values |
| lo_oe | output | 4 | Lower bus output enables |
| lo_i | input | 4 | Lower bus input values |
| up_o | output | 4 | Upper bus output values |
| up_oe | output | 4 | Upper bus output enables |
| up_i | input | 4 | Upper bus input values |

## Verification
The properties assume that `tx_data` stays steady while `tx_valid` is high, that `start` comes only while the block is idle, and that the flash models change `lo_i`/`up_i` only after a falling `sck`. The bench device models update their read lines on the falling serial clock and capture write bits on the rising one. Handshake inputs are driven half a system cycle away from the sampling edge. Backpressure is introduced only at defined points: a gap inside a striped write pair, and a stall between the two halves of a striped read pair.

// File: rtl/dpar_flash_stripe.sv
module dpar_flash_stripe #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cfg_tgt,
  input  logic [1:0]        cfg_wid,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [LEN_W-1:0]  cfg_len,
  output logic              done,
  output logic              err,
  input  logic [7:0]        tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [7:0]        rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              sck,
  output logic              cs_n,
  output logic [3:0]        lo_o,
  output logic [3:0]        lo_oe,
  input  logic [3:0]        lo_i,
  output logic [3:0]        up_o,
  output logic [3:0]        up_oe,
  input  logic [3:0]        up_i
);

  localparam logic [1:0] T_MIR = 2'd0, T_LO = 2'd1, T_UP = 2'd2, T_STR = 2'd3;
  localparam logic [1:0] W_1 = 2'd0, W_2 = 2'd1, W_4 = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_LOAD, S_SHIFT, S_RXOUT, S_TAIL, S_FIN} st_t;

  st_t              st;
  logic [1:0]       t_tgt, t_wid;
  logic             t_rd;
  logic [LEN_W-1:0] slots;
  logic             ph, half, rxsel, last, err_q;
  logic [2:0]       beat;
  logic [7:0]       sh_lo, sh_hi;
  logic [3:0]       cap_lo, cap_hi;

  function automatic logic [3:0] bits_out(input logic [7:0] s, input logic [1:0] w);
    case (w)
      W_1:     return {3'b000, s[7]};
      W_2:     return {2'b00, s[7:6]};
      default: return s[7:4];
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] w);
    case (w)
      W_1:     return 4'b0001;
      W_2:     return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [7:0] bits_in(input logic [7:0] s, input logic [3:0] c, input logic [1:0] w);
    case (w)
      W_1:     return {s[6:0], c[1]};
      W_2:     return {s[5:0], c[1:0]};
      default: return {s[3:0], c[3:0]};
    endcase
  endfunction

  wire is_str  = (t_tgt == T_STR);
  wire lo_act  = (t_tgt != T_UP);
  wire up_act  = (t_tgt != T_LO);
  wire drv     = (st == S_SHIFT) && !t_rd;

  wire bad_req = (cfg_len == '0) || (cfg_wid == 2'b11) ||
                 ((cfg_tgt == T_STR) && (cfg_addr[0] || cfg_len[0]));
  wire [LEN_W-1:0] slots_in = (cfg_tgt == T_STR) ? (cfg_len >> 1) : cfg_len;

  wire last_beat = (t_wid == W_1) ? (beat == 3'd7) :
                   (t_wid == W_2) ? (beat == 3'd3) : (beat == 3'd1);

  assign sck      = (st == S_SHIFT) && ph;
  assign cs_n     = !((st == S_LEAD) || (st == S_LOAD) || (st == S_SHIFT) ||
                      (st == S_TAIL) || ((st == S_RXOUT) && !last));
  assign lo_oe    = (drv && lo_act) ? lane_mask(t_wid) : 4'b0000;
  assign up_oe    = (drv && up_act) ? lane_mask(t_wid) : 4'b0000;
  assign lo_o     = (drv && lo_act) ? bits_out(sh_lo, t_wid) : 4'b0000;
  assign up_o     = (drv && up_act) ? bits_out(sh_hi, t_wid) : 4'b0000;
  assign tx_ready = (st == S_LOAD);
  assign rx_valid = (st == S_RXOUT);
  assign rx_data  = (is_str ? rxsel : (t_tgt == T_UP)) ? sh_hi : sh_lo;
  assign done     = (st == S_FIN);
  assign err      = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      t_tgt  <= T_MIR;
      t_wid  <= W_1;
      t_rd   <= 1'b0;
      slots  <= '0;
      ph     <= 1'b0;
      half   <= 1'b0;
      rxsel  <= 1'b0;
      last   <= 1'b0;
      err_q  <= 1'b0;
      beat   <= 3'd0;
      sh_lo  <= 8'h00;
      sh_hi  <= 8'h00;
      cap_lo <= 4'h0;
      cap_hi <= 4'h0;
    end else begin
      err_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (bad_req) err_q <= 1'b1;
          else begin
            t_tgt <= cfg_tgt;
            t_wid <= cfg_wid;
            t_rd  <= cfg_rd;
            slots <= slots_in;
            half  <= 1'b0;
            rxsel <= 1'b0;
            last  <= 1'b0;
            st    <= S_LEAD;
          end
        end
        S_LEAD: begin
          ph   <= 1'b0;
          beat <= 3'd0;
          st   <= t_rd ? S_SHIFT : S_LOAD;
        end
        S_LOAD: if (tx_valid) begin
          if (is_str && !half) begin
            sh_lo <= tx_data;
            half  <= 1'b1;
          end else begin
            if (is_str) sh_hi <= tx_data;
            else begin
              sh_lo <= tx_data;
              sh_hi <= tx_data;
            end
            half <= 1'b0;
            ph   <= 1'b0;
            beat <= 3'd0;
            st   <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          ph <= !ph;
          if (!ph) begin
            cap_lo <= lo_i;
            cap_hi <= up_i;
          end else begin
            sh_lo <= bits_in(sh_lo, cap_lo, t_wid);
            sh_hi <= bits_in(sh_hi, cap_hi, t_wid);
            beat  <= beat + 3'd1;
            if (last_beat) begin
              beat  <= 3'd0;
              slots <= slots - 1'b1;
              if (slots == 1) begin
                last <= 1'b1;
                st   <= S_TAIL;
              end else begin
                st <= t_rd ? S_RXOUT : S_LOAD;
              end
            end
          end
        end
        S_TAIL: st <= t_rd ? S_RXOUT : S_FIN;
        S_RXOUT: if (rx_ready) begin
          if (is_str && !rxsel) rxsel <= 1'b1;
          else begin
            rxsel <= 1'b0;
            ph    <= 1'b0;
            st    <= last ? S_FIN : S_SHIFT;
          end
        end
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck); // R2
  AST_CS_LEAD: assert property (@(posedge clk) disable iff (!rst_n) $rose(sck) |-> $past(!cs_n)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) done |-> cs_n); // R9
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) err |-> (cs_n && !sck && !done)); // R8
  AST_LO_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (t_tgt == T_UP) |-> (lo_oe == 4'b0000)); // R4
  AST_UP_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (t_tgt == T_LO) |-> (up_oe == 4'b0000)); // R4
  AST_READ_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n) t_rd |-> ((lo_oe | up_oe) == 4'b0000)); // R7
  AST_PAIR_WAIT: assert property (@(posedge clk) disable iff (!rst_n) tx_ready |-> !sck); // R10
  AST_RX_HALT: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> !sck); // R11
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R11

endmodule

// File: tb/dpar_flash_stripe_tb.sv
module dpar_flash_stripe_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        start = 1'b0;
  logic [1:0]  cfg_tgt = 2'd0, cfg_wid = 2'd0;
  logic        cfg_rd = 1'b0;
  logic [31:0] cfg_addr = 32'd0;
  logic [15:0] cfg_len = 16'd0;
  logic        done, err, tx_ready, rx_valid, sck, cs_n;
  logic [7:0]  tx_data = 8'h00, rx_data;
  logic        tx_valid = 1'b0, rx_ready = 1'b1;
  logic [3:0]  lo_o, lo_oe, up_o, up_oe, lo_i, up_i;

  dpar_flash_stripe dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_tgt(cfg_tgt), .cfg_wid(cfg_wid),
    .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_len(cfg_len), .done(done), .err(err),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .sck(sck), .cs_n(cs_n), .lo_o(lo_o), .lo_oe(lo_oe), .lo_i(lo_i),
    .up_o(up_o), .up_oe(up_oe), .up_i(up_i));

  int total = 0, bad = 0;

  // device models
  logic        mdl_clr = 1'b0;
  int          rw = 1;
  logic [63:0] lo_rd_bits = 64'd0, up_rd_bits = 64'd0;
  int          lo_k, up_k, sck_n, cs_falls, lo_nw, up_nw, lo_bits, up_bits;
  logic [7:0]  lo_acc, up_acc;
  logic [7:0]  lo_got [0:7];
  logic [7:0]  up_got [0:7];

  always @(negedge sck or posedge mdl_clr) begin
    if (mdl_clr) begin lo_k = 0; up_k = 0; end
    else begin lo_k = lo_k + rw; up_k = up_k + rw; end
  end

  logic [63:0] lo_win, up_win;
  always_comb begin
    lo_win = lo_rd_bits << lo_k;
    up_win = up_rd_bits << up_k;
    case (rw)
      4:       begin lo_i = lo_win[63:60];                  up_i = up_win[63:60]; end
      2:       begin lo_i = {2'b00, lo_win[63:62]};         up_i = {2'b00, up_win[63:62]}; end
      default: begin lo_i = {2'b00, lo_win[63], 1'b0};      up_i = {2'b00, up_win[63], 1'b0}; end
    endcase
  end

  always @(posedge sck or posedge mdl_clr) begin
    if (mdl_clr) begin
      sck_n = 0; lo_nw = 0; up_nw = 0; lo_bits = 0; up_bits = 0; lo_acc = 0; up_acc = 0;
    end else begin
      sck_n = sck_n + 1;
      if (lo_oe != 4'b0000) begin
        case (lo_oe)
          4'b0001: begin lo_acc = {lo_acc[6:0], lo_o[0]};   lo_bits = lo_bits + 1; end
          4'b0011: begin lo_acc = {lo_acc[5:0], lo_o[1:0]}; lo_bits = lo_bits + 2; end
          default: begin lo_acc = {lo_acc[3:0], lo_o[3:0]}; lo_bits = lo_bits + 4; end
        endcase
        if (lo_bits == 8) begin
          if (lo_nw < 8) lo_got[lo_nw] = lo_acc;
          lo_nw = lo_nw + 1; lo_bits = 0;
        end
      end
      if (up_oe != 4'b0000) begin
        case (up_oe)
          4'b0001: begin up_acc = {up_acc[6:0], up_o[0]};   up_bits = up_bits + 1; end
          4'b0011: begin up_acc = {up_acc[5:0], up_o[1:0]}; up_bits = up_bits + 2; end
          default: begin up_acc = {up_acc[3:0], up_o[3:0]}; up_bits = up_bits + 4; end
        endcase
        if (up_bits == 8) begin
          if (up_nw < 8) up_got[up_nw] = up_acc;
          up_nw = up_nw + 1; up_bits = 0;
        end
      end
    end
  end

  always @(negedge cs_n or posedge mdl_clr) begin
    if (mdl_clr) cs_falls = 0;
    else cs_falls = cs_falls + 1;
  end

  logic [7:0] txq [0:7];
  logic [7:0] rxq [0:7];
  int ntx, n_rx, sck_gap, sck_st0, sck_st1;
  bit seen_done, seen_err;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] tg, input logic [1:0] wd, input logic rd,
                     input logic [31:0] ad, input logic [15:0] ln,
                     input int gap_at, input int gap_n, input int stall_at, input int stall_n);
    int tp, rq, gc, sc;
    bit fin;
    tp = 0; rq = 0; gc = 0; sc = 0; fin = 0;
    seen_done = 0; seen_err = 0; sck_gap = -1; sck_st0 = -1; sck_st1 = -1;
    rw = (wd == 2'd2) ? 4 : (wd == 2'd1) ? 2 : 1;
    mdl_clr = 1'b1; #1 mdl_clr = 1'b0;
    @(negedge clk);
    cfg_tgt = tg; cfg_wid = wd; cfg_rd = rd; cfg_addr = ad; cfg_len = ln; start = 1'b1;
    for (int i = 0; i < 3000 && !fin; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (err) begin seen_err = 1; fin = 1; end
      if (done) begin seen_done = 1; fin = 1; end
      if (tp < ntx) begin
        if (tp == gap_at && gc < gap_n) begin
          tx_valid = 1'b0; gc++;
          if (gc == gap_n) sck_gap = sck_n;
        end else begin
          tx_valid = 1'b1; tx_data = txq[tp];
        end
      end else tx_valid = 1'b0;
      if (tx_valid && tx_ready) tp++;
      if (rq == stall_at && sc < stall_n) begin
        rx_ready = 1'b0;
        if (sc == 0) sck_st0 = sck_n;
        sc++;
        if (sc == stall_n) sck_st1 = sck_n;
      end else rx_ready = 1'b1;
      if (rx_valid && rx_ready) begin
        if (rq < 8) rxq[rq] = rx_data;
        rq++;
      end
    end
    tx_valid = 1'b0; rx_ready = 1'b1;
    repeat (10) begin
      @(negedge clk);
      if (done) seen_done = 1;
    end
    n_rx = rq;
  endtask

  task automatic t_reset;
    chk("R1 cs_n idle", cs_n, 1);
    chk("R1 sck idle", sck, 0);
    chk("R1 oe idle", {lo_oe, up_oe}, 0);
    chk("R1 done/err idle", {done, err}, 0);
    chk("R1 handshakes idle", {tx_ready, rx_valid}, 0);
  endtask

  task automatic t_mirror_write;
    txq[0] = 8'hA5; ntx = 1;
    run(2'd0, 2'd0, 1'b0, 32'd0, 16'd1, -1, 0, -1, 0);
    chk("R3 mirror lower byte", {lo_nw, lo_got[0]}, {24'd1, 8'hA5});
    chk("R3 mirror upper byte", {up_nw, up_got[0]}, {24'd1, 8'hA5});
    chk("R2 single width pulses", sck_n, 8);
    chk("R9 done after write", seen_done, 1);
    chk("R9 cs released", cs_n, 1);
  endtask

  task automatic t_lower_only;
    txq[0] = 8'h3C; ntx = 1;
    run(2'd1, 2'd1, 1'b0, 32'd0, 16'd1, -1, 0, -1, 0);
    chk("R4 lower got byte", {lo_nw, lo_got[0]}, {24'd1, 8'h3C});
    chk("R4 upper untouched", up_nw, 0);
    chk("R2 dual width pulses", sck_n, 4);
  endtask

  task automatic t_upper_only;
    txq[0] = 8'hE1; txq[1] = 8'h7F; txq[2] = 8'h08; ntx = 3;
    run(2'd2, 2'd2, 1'b0, 32'd5, 16'd3, -1, 0, -1, 0);
    chk("R4 upper count", up_nw, 3);
    chk("R4 upper bytes", {up_got[0], up_got[1], up_got[2]}, {8'h00, 8'hE1, 8'h7F, 8'h08});
    chk("R4 lower untouched", lo_nw, 0);
    chk("R2 quad width pulses", sck_n, 6);
  endtask

  task automatic t_stripe_write_quad;
    txq[0] = 8'h11; txq[1] = 8'h22; txq[2] = 8'h33; txq[3] = 8'h44; ntx = 4;
    run(2'd3, 2'd2, 1'b0, 32'd8, 16'd4, 1, 6, -1, 0);
    chk("R5 lower even bytes", {lo_nw, lo_got[0], lo_got[1]}, {16'd2, 8'h11, 8'h33});
    chk("R5 upper odd bytes", {up_nw, up_got[0], up_got[1]}, {16'd2, 8'h22, 8'h44});
    chk("R5 pair shares pulses", sck_n, 4);
    chk("R10 no pulse before pair complete", sck_gap, 0);
    chk("R9 done striped", seen_done, 1);
  endtask

  task automatic t_stripe_write_single;
    txq[0] = 8'h81; txq[1] = 8'h42; ntx = 2;
    run(2'd3, 2'd0, 1'b0, 32'd0, 16'd2, -1, 0, -1, 0);
    chk("R5 single lower", {lo_nw, lo_got[0]}, {24'd1, 8'h81});
    chk("R5 single upper", {up_nw, up_got[0]}, {24'd1, 8'h42});
    chk("R5 single pulses", sck_n, 8);
  endtask

  task automatic t_stripe_read_dual;
    ntx = 0;
    lo_rd_bits = {8'hA1, 8'hA3, 48'd0};
    up_rd_bits = {8'hB2, 8'hB4, 48'd0};
    run(2'd3, 2'd1, 1'b1, 32'd2, 16'd4, -1, 0, 1, 7);
    chk("R6 read count", n_rx, 4);
    chk("R6 read order", {rxq[0], rxq[1], rxq[2], rxq[3]}, {8'hA1, 8'hB2, 8'hA3, 8'hB4});
    chk("R11 sck frozen while stalled", sck_st1, sck_st0);
    chk("R11 stall after first pair", sck_st1, 4);
    chk("R7 read leaves buses undriven", {lo_nw, up_nw}, 0);
    chk("R9 done after read", seen_done, 1);
  endtask

  task automatic t_mirror_read;
    ntx = 0;
    lo_rd_bits = {8'h5A, 56'd0};
    up_rd_bits = {8'hFF, 56'd0};
    run(2'd0, 2'd0, 1'b1, 32'd0, 16'd1, -1, 0, -1, 0);
    chk("R7 mirror read uses lower", {n_rx[7:0], rxq[0]}, {8'd1, 8'h5A});
  endtask

  task automatic t_upper_read;
    ntx = 0;
    lo_rd_bits = 64'd0;
    up_rd_bits = {8'hC7, 56'd0};
    run(2'd2, 2'd2, 1'b1, 32'd0, 16'd1, -1, 0, -1, 0);
    chk("R7 upper read", {n_rx[7:0], rxq[0]}, {8'd1, 8'hC7});
  endtask

  task automatic t_reject(input string tag, input logic [1:0] tg, input logic [1:0] wd,
                          input logic [31:0] ad, input logic [15:0] ln);
    ntx = 0;
    run(tg, wd, 1'b0, ad, ln, -1, 0, -1, 0);
    chk({"R8 err ", tag}, seen_err, 1);
    chk({"R8 no done ", tag}, seen_done, 0);
    chk({"R8 no edges ", tag}, {sck_n[15:0], cs_falls[15:0]}, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    ntx = 0;
    mdl_clr = 1'b1; #1 mdl_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mirror_write();
    t_lower_only();
    t_upper_only();
    t_stripe_write_quad();
    t_stripe_write_single();
    t_stripe_read_dual();
    t_mirror_read();
    t_upper_read();
    t_reject("odd addr", 2'd3, 2'd2, 32'd3, 16'd4);
    t_reject("odd len", 2'd3, 2'd1, 32'd0, 16'd3);
    t_reject("bad width", 2'd0, 2'd3, 32'd0, 16'd1);
    t_reject("zero len", 2'd1, 2'd0, 32'd0, 16'd0);
    t_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule